// File: doc/BRIEF.md
# Nibble-Wide Accumulator Processor Core

This block is a small multicycle processor with one shared memory for program and data. Its data path is four bits wide and its instruction set has sixteen opcodes. Every instruction is one opcode nibble. Some instructions also take one operand nibble: the port-select nibble of input and output. Others take two address nibbles: jumps, memory reads and memory writes. The core fetches exactly one nibble from memory per cycle. An instruction with more nibbles therefore takes more cycles.

The memory has 256 words of four bits. Reset fills it from a constant image that is given as a parameter. Reset also clears the program counter and starts fetching at address 0. The core has two 4-bit switch inputs, left and right. It also has two 4-bit display registers, high and low. The default image is a multiply routine. It reads both switch values and shows their 8-bit product on the high and low display registers.

Top module: `nib_cpu`

## Requirements
- R1: While reset is asserted, both display outputs read 0. On release, the program counter is 0 and memory word i holds nibble i of the image. Nibble 0 is the leftmost nibble of the IMG_LEN-nibble image literal. Words beyond IMG_LEN are 0.
- R2: Instruction timing depends on the opcode.
  - Opcodes 0–7, 10 and 11 take 2 cycles.
  - Opcodes 14 and 15 take 3 cycles.
  - Opcodes 8, 9, 12 and 13 take 5 cycles.
  - Every fetched nibble advances the program counter by 1.
- R3: ADD (opcode 0) writes {C,A} = {0,A} + B. INC (opcode 2) writes {C,A} = {0,A} + 1.
- R4: SUB (opcode 1) writes {C,A} = {1,A} − B. DEC (opcode 3) writes {C,A} = {1,A} − 1. As a result, C = 1 means no borrow occurred.
- R5: NOT (4), AND (5), OR (6) and XOR (7) each write A = ~A, A&B, A|B or A^B. C is left unchanged.
- R6: SWAP (10) exchanges A and B in one execute cycle. CPY (11) sets B = A and leaves A unchanged. Neither changes C.
- R7: JMPU (8) and JMPC (9) take two nibbles after the opcode: first the high half of an address, then the low half. JMPU always loads the PC with this address. JMPC loads it only when C = 0; otherwise execution continues after the address nibbles.
- R8: WR (12) stores A at the two-nibble address, high nibble first. RD (13) loads A from that address.
- R9: IN (14) and OUT (15) take one operand nibble. If its bit 3 is 1, IN reads the left switches and OUT writes the high display. If bit 3 is 0, IN reads the right switches and OUT writes the low display. Bits 2:0 are ignored. The displays change only through OUT.
- R10: The program counter wraps from 255 to 0, including while an operand nibble is fetched at address 255.
- R11: With the default image, {disp_hi, disp_lo} eventually equals sw_left × sw_right, within 1000 cycles of reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_left | input | 4 | Left switch value, read by IN with operand bit 3 set |
| sw_right | input | 4 | Right switch value, read by IN with operand bit 3 clear |
| disp_hi | output | 4 | High display register |
| disp_lo | output | 4 | Low display register |

## Verification
The properties assume a few things about the block's use:
- Reset is asserted before the first clock edge.
- The core only ever runs a loaded image, so the state and instruction register always hold legal values.
- The switch inputs do not matter to any property, because they feed only the accumulator.

The stimulus keeps the switches constant while a program runs and changes them only while reset is held. Because of this, an instruction-level model in the bench can predict every display value at each instruction boundary, with the same switch values as the core sees.

// File: rtl/nib_cpu.sv
module nib_cpu #(
  parameter int DW = 4,
  parameter int IMG_LEN = 65,
  parameter logic [DW*(1<<(2*DW))-1:0] IMG =
    260'hE8CF0E0CF1B7CF2CF3DF13934CF1DF2BDF00CF2931DF32CF3812DF2F0DF3F883E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sw_left,
  input  logic [DW-1:0] sw_right,
  output logic [DW-1:0] disp_hi,
  output logic [DW-1:0] disp_lo
);
  localparam int AW = 2 * DW;
  localparam int DEPTH = 1 << AW;

  localparam logic [DW-1:0] OP_ADD = DW'(0),  OP_SUB = DW'(1),  OP_INC = DW'(2),  OP_DEC = DW'(3);
  localparam logic [DW-1:0] OP_NOT = DW'(4),  OP_AND = DW'(5),  OP_OR  = DW'(6),  OP_XOR = DW'(7);
  localparam logic [DW-1:0] OP_JMP = DW'(8),  OP_JC  = DW'(9),  OP_SWP = DW'(10), OP_CPY = DW'(11);
  localparam logic [DW-1:0] OP_WR  = DW'(12), OP_RD  = DW'(13), OP_IN  = DW'(14), OP_OUT = DW'(15);

  localparam logic [2:0] S_FETCH = 3'd0, S_EXEC = 3'd1, S_ADRH = 3'd2,
                         S_ADRL  = 3'd3, S_MEM  = 3'd4, S_IO   = 3'd5;

  function automatic logic [DW*DEPTH-1:0] boot_table();
    logic [DW*DEPTH-1:0] t;
    t = '0;
    for (int i = 0; i < IMG_LEN && i < DEPTH; i++)
      t[DW*i +: DW] = IMG[DW*(IMG_LEN-1-i) +: DW];
    return t;
  endfunction

  localparam logic [DW*DEPTH-1:0] BOOT = boot_table();

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, acc, opb, mah, mal, cur;
  logic          cy;
  logic [2:0]    st;
  logic [DW:0]   alu;

  assign cur = mem[pc];

  always_comb begin
    case (ir)
      OP_SUB:  alu = {1'b1, acc} - {1'b0, opb};
      OP_INC:  alu = {1'b0, acc} + 1'b1;
      OP_DEC:  alu = {1'b1, acc} - 1'b1;
      default: alu = {1'b0, acc} + {1'b0, opb};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BOOT[DW*i +: DW];
      pc <= '0;
      ir <= '0;
      acc <= '0;
      opb <= '0;
      mah <= '0;
      mal <= '0;
      cy <= 1'b0;
      disp_hi <= '0;
      disp_lo <= '0;
      st <= S_FETCH;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= cur;
          pc <= pc + 1'b1;
          st <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (ir)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: {cy, acc} <= alu;
            OP_NOT: acc <= ~acc;
            OP_AND: acc <= acc & opb;
            OP_OR:  acc <= acc | opb;
            OP_XOR: acc <= acc ^ opb;
            OP_SWP: begin
              acc <= opb;
              opb <= acc;
            end
            OP_CPY: opb <= acc;
            OP_IN, OP_OUT: st <= S_IO;
            default: st <= S_ADRH;
          endcase
        end
        S_ADRH: begin
          mah <= cur;
          pc <= pc + 1'b1;
          st <= S_ADRL;
        end
        S_ADRL: begin
          mal <= cur;
          pc <= pc + 1'b1;
          st <= S_MEM;
        end
        S_MEM: begin
          st <= S_FETCH;
          case (ir)
            OP_JMP: pc <= {mah, mal};
            OP_JC:  if (!cy) pc <= {mah, mal};
            OP_WR:  mem[{mah, mal}] <= acc;
            OP_RD:  acc <= mem[{mah, mal}];
            default: ;
          endcase
        end
        S_IO: begin
          pc <= pc + 1'b1;
          st <= S_FETCH;
          if (ir == OP_IN) acc <= cur[DW-1] ? sw_left : sw_right;
          else if (cur[DW-1]) disp_hi <= acc;
          else disp_lo <= acc;
        end
        default: st <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk #(
  parameter int DW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      st,
  input logic [DW-1:0]   ir,
  input logic [2*DW-1:0] pc,
  input logic [DW-1:0]   mah,
  input logic [DW-1:0]   mal,
  input logic [DW-1:0]   a,
  input logic [DW-1:0]   b,
  input logic            c,
  input logic [DW-1:0]   disp_hi,
  input logic [DW-1:0]   disp_lo
);
  localparam logic [2:0] C_FETCH = 3'd0, C_EXEC = 3'd1, C_MEM = 3'd4, C_IO = 3'd5;

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_FETCH |=> st == C_EXEC && pc == (2*DW)'($past(pc) + 1'b1));

  p_io_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_IO |=> st == C_FETCH && pc == (2*DW)'($past(pc) + 1'b1));

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_FETCH && pc == '1) |=> pc == '0);

  p_keep_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_EXEC && ir >= DW'(4) && ir <= DW'(7)) |=> $stable(c));

  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_EXEC && ir == DW'(10)) |=> a == $past(b) && b == $past(a) && $stable(c));

  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_MEM && ir == DW'(8)) |=> pc == $past({mah, mal}));

  p_jc_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_MEM && ir == DW'(9) && c) |=> $stable(pc));

  p_disp_only_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == C_IO && ir == DW'(15)) |=> $stable(disp_hi) && $stable(disp_lo));
endmodule

bind nib_cpu nib_cpu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .ir(ir), .pc(pc), .mah(mah), .mal(mal),
  .a(acc), .b(opb), .c(cy), .disp_hi(disp_hi), .disp_lo(disp_lo)
);

// File: tb/sim_nib_cpu.sv
`timescale 1ns/1ps
module sim_nib_cpu;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [207:0] T_HEAD = 208'hE8BE0F00F89104F01F89192F03F85F06F87F0AF8C804D80F08FD;

  function automatic logic [1023:0] mk_img();
    logic [1023:0] r;
    r = '0;
    for (int i = 0; i < 52; i++) r[4*(255-i) +: 4] = T_HEAD[4*(51-i) +: 4];
    r[8 +: 4] = 4'h2;
    r[4 +: 4] = 4'hF;
    r[0 +: 4] = 4'h0;
    return r;
  endfunction

  localparam logic [1023:0] T_IMG = mk_img();

  logic rst0_n = 1'b0, rst1_n = 1'b0;
  logic [3:0] swl0 = '0, swr0 = '0, swl1 = '0, swr1 = '0;
  logic [3:0] dh0, dl0, dh1, dl1;

  nib_cpu u0 (.clk(clk), .rst_n(rst0_n), .sw_left(swl0), .sw_right(swr0),
              .disp_hi(dh0), .disp_lo(dl0));

  nib_cpu #(.IMG_LEN(256), .IMG(T_IMG)) u1 (
    .clk(clk), .rst_n(rst1_n), .sw_left(swl1), .sw_right(swr1),
    .disp_hi(dh1), .disp_lo(dl1));

  logic [3:0] m_mem [256];
  logic [7:0] m_pc;
  logic [3:0] m_a, m_b, m_dh, m_dl;
  logic       m_c;

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic m_load();
    for (int i = 0; i < 256; i++) m_mem[i] = T_IMG[4*(255-i) +: 4];
    m_pc = '0; m_a = '0; m_b = '0; m_c = 1'b0; m_dh = '0; m_dl = '0;
  endtask

  task automatic m_step(output int cyc, output logic [3:0] op);
    logic [3:0] t, h, l;
    logic [4:0] r;
    op = m_mem[m_pc]; m_pc = m_pc + 8'd1; cyc = 2;
    case (op)
      4'd0: begin r = {1'b0, m_a} + {1'b0, m_b}; {m_c, m_a} = r; end
      4'd1: begin r = {1'b1, m_a} - {1'b0, m_b}; {m_c, m_a} = r; end
      4'd2: begin r = {1'b0, m_a} + 5'd1; {m_c, m_a} = r; end
      4'd3: begin r = {1'b1, m_a} - 5'd1; {m_c, m_a} = r; end
      4'd4: m_a = ~m_a;
      4'd5: m_a = m_a & m_b;
      4'd6: m_a = m_a | m_b;
      4'd7: m_a = m_a ^ m_b;
      4'd10: begin t = m_a; m_a = m_b; m_b = t; end
      4'd11: m_b = m_a;
      4'd14, 4'd15: begin
        t = m_mem[m_pc]; m_pc = m_pc + 8'd1; cyc = 3;
        if (op == 4'd14) m_a = t[3] ? swl1 : swr1;
        else if (t[3]) m_dh = m_a;
        else m_dl = m_a;
      end
      default: begin
        h = m_mem[m_pc]; m_pc = m_pc + 8'd1;
        l = m_mem[m_pc]; m_pc = m_pc + 8'd1;
        cyc = 5;
        case (op)
          4'd8:  m_pc = {h, l};
          4'd9:  if (!m_c) m_pc = {h, l};
          4'd12: m_mem[{h, l}] = m_a;
          default: m_a = m_mem[{h, l}];
        endcase
      end
    endcase
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd2: return "R3";
      4'd1, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd10, 4'd11: return "R6";
      4'd8, 4'd9: return "R7";
      4'd12, 4'd13: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_isa(input logic [3:0] l, input logic [3:0] r);
    int cyc;
    logic [3:0] op;
    logic [7:0] pc0;
    string tag;
    @(negedge clk);
    rst1_n = 1'b0; swl1 = l; swr1 = r;
    repeat (2) @(negedge clk);
    chk("R1", "displays in reset", {dh1, dl1}, 8'h00);
    m_load();
    rst1_n = 1'b1;
    for (int s = 0; s < 60; s++) begin
      pc0 = m_pc;
      m_step(cyc, op);
      repeat (cyc) @(posedge clk);
      @(negedge clk);
      tag = (m_pc < pc0 && op != 4'd8 && op != 4'd9) ? "R10" : op_tag(op);
      chk(tag, $sformatf("R2 displays after op %0d at pc %h", op, pc0), {dh1, dl1}, {m_dh, m_dl});
    end
  endtask

  task automatic run_mul(input logic [3:0] l, input logic [3:0] r);
    @(negedge clk);
    rst0_n = 1'b0; swl0 = l; swr0 = r;
    repeat (2) @(negedge clk);
    chk("R1", "product displays in reset", {dh0, dl0}, 8'h00);
    rst0_n = 1'b1;
    repeat (1000) @(posedge clk);
    @(negedge clk);
    chk("R11", $sformatf("product %0d x %0d", l, r), {dh0, dl0}, 8'(l * r));
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    run_isa(4'hF, 4'h1);
    run_isa(4'h0, 4'h0);
    run_isa(4'h8, 4'h8);
    run_isa(4'h1, 4'hF);
    for (int k = 0; k < 20; k++) run_isa(4'($urandom), 4'($urandom));
    run_mul(4'h0, 4'h0);
    run_mul(4'hF, 4'hF);
    run_mul(4'hF, 4'h1);
    run_mul(4'h1, 4'hF);
    run_mul(4'h0, 4'hF);
    run_mul(4'hF, 4'h0);
    for (int k = 0; k < 40; k++) run_mul(4'($urandom), 4'($urandom));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule